// File: doc/BRIEF.md
# Serial Control Register Command Unit

This unit sits behind a byte-level two-wire slave front end. The front end reports bus events to it: a start, a stop, a received byte, or a read request. From these events the unit keeps a one-byte control register. The register holds a watchdog interval field, a power-up delay field and a block protect bit. Writes to the register pass through two volatile enable latches, and only the first data byte of a transfer counts. A store is committed when the STOP arrives. A busy window follows each commit, and for its length the unit refuses all traffic.

The same decoder also recognises four threshold commands: set and reset, for each of two supply thresholds. These commands are honoured only while an external high-voltage-present flag is high. Each one is issued as a single-cycle pulse after its STOP. Bit timing on the wire and the non-volatile cell operation are handled elsewhere.

Top module: `ctlreg_cmd_unit`

## Requirements
- R1: After reset the register reads the `CFG_INIT` value with both enable latches at 0 (default 00h). `busy_o`, `ack_vld_o`, `rd_vld_o`, `commit_o` and both threshold pulses are 0.
- R2: Every byte presented with `byte_vld_i` is answered by `ack_vld_o` in the following cycle. `ack_o` in that cycle is 1 when the byte is accepted and 0 when it is refused.
- R3: The register is addressed by a slave byte with bits 7:4 = 1011, bit 1 = 1 (address bit 8) and bit 0 as read/write (0 = write). The next address byte must be FFh. Any other slave byte (other than the threshold one in R10), and any other address byte, is refused.
- R4: Register layout, bit 7 down to bit 0: PUP1, WD1, WD0, BP, constant 0, RWEL, WEL, PUP0. A data byte with bit 1 = 1 and bit 2 = 0 sets WEL. A data byte with bits 1 and 2 both 1, written while WEL is already 1, sets RWEL. Both take effect on STOP.
- R5: A data byte written while RWEL is 1 is a store. It loads bits 7, 6, 5, 4 and 0 into the register and clears WEL and RWEL. `commit_o` pulses in the cycle after the STOP, and the new value is visible on `cfg_o` one cycle later.
- R6: A data byte written while RWEL is 0 is acknowledged but leaves PUP1, WD1, WD0, BP and PUP0 unchanged.
- R7: In a write transfer only the first data byte is acknowledged. Later data bytes are refused and have no effect.
- R8: A START that arrives before the STOP discards the pending write or command.
- R9: A read slave byte (bit 0 = 1) that follows an address byte FFh returns the register once. The first `rd_req_i` gives `rd_vld_o` with `rd_data_o` = `cfg_o` in the next cycle. Further requests in the same read return nothing. The read needs no STOP.
- R10: With `hv_i` high, the sequence slave byte A0h, address 01h (first threshold) or 09h (second threshold), data 00h is a threshold-set command. After STOP it gives a one-cycle `trip_set_o` pulse, with `trip_sel_o` = 0 for the first threshold and 1 for the second. A non-zero data byte is refused. The register is not changed.
- R11: With `hv_i` high, the same sequence with address 03h (first) or 0Bh (second) gives a one-cycle `trip_clr_o` pulse after STOP, with `trip_sel_o` selecting the threshold as in R10.
- R12: With `hv_i` low, slave byte A0h is refused. If `hv_i` is low at the STOP, a pending threshold command is dropped.
- R13: Each commit or threshold pulse raises `busy_o` in the same cycle, and `busy_o` stays high for exactly `BUSY_CYCLES` cycles. Every byte that starts a transfer while `busy_o` is high is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START (or repeated START) seen on the bus |
| stop_i | input | 1 | STOP seen on the bus |
| byte_vld_i | input | 1 | A byte from the master is available |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Front end requests a byte to send to the master |
| hv_i | input | 1 | High programming voltage present |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_vld_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| cfg_o | output | 8 | Current register value |
| commit_o | output | 1 | Non-volatile store start pulse |
| trip_set_o | output | 1 | Threshold set pulse |
| trip_clr_o | output | 1 | Threshold reset pulse |
| trip_sel_o | output | 1 | Threshold select for the pulses |
| busy_o | output | 1 | Store or threshold operation in progress |

## Verification
The assertions check properties that hold in every cycle:
- acknowledge and read responses come only one cycle after their request;
- commit and threshold pulses follow a STOP, never overlap, and need the high-voltage flag;
- the register changes only two cycles after a STOP;
- both enable latches read 0 after a commit;
- busy follows every commit;
- nothing is acknowledged while busy.

Only the bench scenarios can show the effects that depend on a sequence: the three-step unlock, the discarding on restart, the refusal of a second data byte, the single-byte read, and the exact length of the busy window.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int CFG_W  = 8;
  localparam int B_PUP0 = 0;
  localparam int B_WEL  = 1;
  localparam int B_RWEL = 2;
  localparam int B_BP   = 4;
  localparam int B_WD0  = 5;
  localparam int B_WD1  = 6;
  localparam int B_PUP1 = 7;
  // bits that survive a store
  localparam logic [CFG_W-1:0] NV_MASK = 8'hF1;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_HDR, SQ_ADDR, SQ_DATA, SQ_EXTRA, SQ_READ, SQ_SKIP
  } seq_st_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_WEL, ACT_RWEL, ACT_STORE, ACT_TSET, ACT_TCLR
  } act_e;
endpackage

// File: rtl/ccu_seq.sv
module ccu_seq
  import ccu_pkg::*;
#(
  parameter logic [3:0]       REG_PRE  = 4'b1011,
  parameter logic [8:0]       REG_ADDR = 9'h1FF,
  parameter logic [CFG_W-1:0] TRIP_DEV = 8'hA0,
  parameter logic [CFG_W-1:0] TSET_A0  = 8'h01,
  parameter logic [CFG_W-1:0] TSET_A1  = 8'h09,
  parameter logic [CFG_W-1:0] TCLR_A0  = 8'h03,
  parameter logic [CFG_W-1:0] TCLR_A1  = 8'h0B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [CFG_W-1:0] byte_i,
  input  logic             rd_req_i,
  input  logic             hv_i,
  input  logic             busy_i,
  input  logic             wel_i,
  input  logic             rwel_i,
  output logic             ack_vld_o,
  output logic             ack_o,
  output logic             rd_vld_o,
  output logic             act_vld_o,
  output act_e             act_o,
  output logic [CFG_W-1:0] act_data_o,
  output logic             act_sel_o
);
  seq_st_e          st_q, st_d;
  logic             trip_q, trip_d;
  logic             ptr_q, ptr_d;
  logic             rd_left_q, rd_left_d;
  act_e             top_q, top_d;
  logic             tsel_q, tsel_d;
  act_e             pend_q, pend_d;
  logic [CFG_W-1:0] pdata_q, pdata_d;
  logic             psel_q, psel_d;
  logic             ackv_q, ackv_d, ack_q, ack_d, rdv_q, rdv_d;
  logic             actv_q, actv_d;
  act_e             act_q, act_d;
  logic [CFG_W-1:0] adata_q, adata_d;
  logic             asel_q, asel_d;

  logic reg_hdr, trip_hdr;
  assign reg_hdr  = (byte_i[7:4] == REG_PRE) && (byte_i[1] == REG_ADDR[8]);
  assign trip_hdr = (byte_i == TRIP_DEV) && hv_i;

  always_comb begin
    st_d = st_q; trip_d = trip_q; ptr_d = ptr_q; rd_left_d = rd_left_q;
    top_d = top_q; tsel_d = tsel_q;
    pend_d = pend_q; pdata_d = pdata_q; psel_d = psel_q;
    ackv_d = byte_vld_i; ack_d = 1'b0; rdv_d = 1'b0;
    actv_d = 1'b0; act_d = act_q; adata_d = adata_q; asel_d = asel_q;
    if (start_i) begin
      st_d = SQ_HDR; pend_d = ACT_NONE; rd_left_d = 1'b0;
    end else if (stop_i) begin
      if ((pend_q != ACT_NONE) && (!trip_q || hv_i)) begin
        actv_d = 1'b1; act_d = pend_q; adata_d = pdata_q; asel_d = psel_q;
      end
      st_d = SQ_IDLE; pend_d = ACT_NONE; rd_left_d = 1'b0;
    end else if (byte_vld_i) begin
      case (st_q)
        SQ_HDR: begin
          if (busy_i) begin
            st_d = SQ_SKIP;
          end else if (reg_hdr) begin
            ack_d = 1'b1; trip_d = 1'b0;
            if (byte_i[0]) begin
              st_d = SQ_READ; rd_left_d = ptr_q;
            end else begin
              st_d = SQ_ADDR;
            end
          end else if (trip_hdr && !byte_i[0]) begin
            ack_d = 1'b1; trip_d = 1'b1; st_d = SQ_ADDR;
          end else begin
            st_d = SQ_SKIP;
          end
        end
        SQ_ADDR: begin
          if (!trip_q) begin
            if (byte_i == REG_ADDR[7:0]) begin
              ack_d = 1'b1; ptr_d = 1'b1; st_d = SQ_DATA;
            end else begin
              ptr_d = 1'b0; st_d = SQ_SKIP;
            end
          end else if (hv_i && (byte_i == TSET_A0 || byte_i == TSET_A1)) begin
            ack_d = 1'b1; top_d = ACT_TSET; tsel_d = (byte_i == TSET_A1); st_d = SQ_DATA;
          end else if (hv_i && (byte_i == TCLR_A0 || byte_i == TCLR_A1)) begin
            ack_d = 1'b1; top_d = ACT_TCLR; tsel_d = (byte_i == TCLR_A1); st_d = SQ_DATA;
          end else begin
            st_d = SQ_SKIP;
          end
        end
        SQ_DATA: begin
          st_d = SQ_EXTRA;
          if (!trip_q) begin
            ack_d = 1'b1; pdata_d = byte_i; psel_d = 1'b0;
            if (rwel_i)                                       pend_d = ACT_STORE;
            else if (wel_i && byte_i[B_WEL] && byte_i[B_RWEL]) pend_d = ACT_RWEL;
            else if (byte_i[B_WEL] && !byte_i[B_RWEL])         pend_d = ACT_WEL;
            else                                               pend_d = ACT_NONE;
          end else if (hv_i && (byte_i == '0)) begin
            ack_d = 1'b1; pend_d = top_q; psel_d = tsel_q; pdata_d = byte_i;
          end else begin
            st_d = SQ_SKIP;
          end
        end
        default: ack_d = 1'b0;
      endcase
    end else if (rd_req_i && (st_q == SQ_READ) && rd_left_q) begin
      rdv_d = 1'b1; rd_left_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; trip_q <= 1'b0; ptr_q <= 1'b0; rd_left_q <= 1'b0;
      top_q <= ACT_NONE; tsel_q <= 1'b0;
      pend_q <= ACT_NONE; pdata_q <= '0; psel_q <= 1'b0;
      ackv_q <= 1'b0; ack_q <= 1'b0; rdv_q <= 1'b0;
      actv_q <= 1'b0; act_q <= ACT_NONE; adata_q <= '0; asel_q <= 1'b0;
    end else begin
      st_q <= st_d; trip_q <= trip_d; ptr_q <= ptr_d; rd_left_q <= rd_left_d;
      top_q <= top_d; tsel_q <= tsel_d;
      pend_q <= pend_d; pdata_q <= pdata_d; psel_q <= psel_d;
      ackv_q <= ackv_d; ack_q <= ack_d; rdv_q <= rdv_d;
      actv_q <= actv_d; act_q <= act_d; adata_q <= adata_d; asel_q <= asel_d;
    end
  end

  assign ack_vld_o  = ackv_q;
  assign ack_o      = ack_q;
  assign rd_vld_o   = rdv_q;
  assign act_vld_o  = actv_q;
  assign act_o      = act_q;
  assign act_data_o = adata_q;
  assign act_sel_o  = asel_q;
endmodule

// File: rtl/ccu_cfg.sv
module ccu_cfg
  import ccu_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_vld_i,
  input  act_e             act_i,
  input  logic [CFG_W-1:0] act_data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             wel_o,
  output logic             rwel_o,
  output logic             commit_o
);
  logic [CFG_W-1:0] nv_q, nv_d;
  logic             wel_q, wel_d, rwel_q, rwel_d;
  logic             nv_en;

  assign nv_en = act_vld_i && (act_i == ACT_STORE);

  always_comb begin
    nv_d = nv_q; wel_d = wel_q; rwel_d = rwel_q;
    if (act_vld_i) begin
      case (act_i)
        ACT_WEL:   wel_d = 1'b1;
        ACT_RWEL:  rwel_d = 1'b1;
        ACT_STORE: begin
          nv_d = act_data_i & NV_MASK; wel_d = 1'b0; rwel_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q <= CFG_INIT & NV_MASK; wel_q <= 1'b0; rwel_q <= 1'b0;
    end else begin
      if (nv_en) nv_q <= nv_d;
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
    end
  end

  always_comb begin
    cfg_o         = nv_q & NV_MASK;
    cfg_o[B_WEL]  = wel_q;
    cfg_o[B_RWEL] = rwel_q;
  end
  assign wel_o    = wel_q;
  assign rwel_o   = rwel_q;
  assign commit_o = nv_en;
endmodule

// File: rtl/ccu_busy.sv
module ccu_busy #(
  parameter int CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (launch_i)          cnt_d = CW'(CYCLES - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = launch_i || (cnt_q != '0);
endmodule

// File: rtl/ctlreg_cmd_unit.sv
module ctlreg_cmd_unit
  import ccu_pkg::*;
#(
  parameter int               BUSY_CYCLES = 24,
  parameter logic [CFG_W-1:0] CFG_INIT    = 8'h00,
  parameter logic [3:0]       REG_PRE     = 4'b1011,
  parameter logic [8:0]       REG_ADDR    = 9'h1FF,
  parameter logic [CFG_W-1:0] TRIP_DEV    = 8'hA0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [CFG_W-1:0] byte_i,
  input  logic             rd_req_i,
  input  logic             hv_i,
  output logic             ack_vld_o,
  output logic             ack_o,
  output logic             rd_vld_o,
  output logic [CFG_W-1:0] rd_data_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             commit_o,
  output logic             trip_set_o,
  output logic             trip_clr_o,
  output logic             trip_sel_o,
  output logic             busy_o
);
  logic             act_vld, act_sel, wel, rwel;
  act_e             act;
  logic [CFG_W-1:0] act_data;

  ccu_seq #(
    .REG_PRE(REG_PRE), .REG_ADDR(REG_ADDR), .TRIP_DEV(TRIP_DEV),
    .TSET_A0(8'h01), .TSET_A1(8'h09), .TCLR_A0(8'h03), .TCLR_A1(8'h0B)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_req_i(rd_req_i),
    .hv_i(hv_i), .busy_i(busy_o), .wel_i(wel), .rwel_i(rwel),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rd_vld_o(rd_vld_o),
    .act_vld_o(act_vld), .act_o(act), .act_data_o(act_data), .act_sel_o(act_sel)
  );

  ccu_cfg #(.CFG_INIT(CFG_INIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .act_vld_i(act_vld), .act_i(act),
    .act_data_i(act_data), .cfg_o(cfg_o), .wel_o(wel), .rwel_o(rwel),
    .commit_o(commit_o)
  );

  assign trip_set_o = act_vld && (act == ACT_TSET);
  assign trip_clr_o = act_vld && (act == ACT_TCLR);
  assign trip_sel_o = act_sel;
  assign rd_data_o  = rd_vld_o ? cfg_o : '0;

  ccu_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .launch_i(commit_o || trip_set_o || trip_clr_o),
    .busy_o(busy_o)
  );
endmodule

// File: rtl/ctlreg_cmd_unit_chk.sv
module ctlreg_cmd_unit_chk #(
  parameter int BUSY_CYCLES = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_i,
  input logic       byte_vld_i,
  input logic       rd_req_i,
  input logic       hv_i,
  input logic       ack_vld_o,
  input logic       ack_o,
  input logic       rd_vld_o,
  input logic [7:0] cfg_o,
  input logic       commit_o,
  input logic       trip_set_o,
  input logic       trip_clr_o,
  input logic       busy_o
);
  p_ack_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> $past(byte_vld_i));
  p_no_ack_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld_o && ack_o) |-> !$past(busy_o));
  p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_i));
  p_latches_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit_o) |-> (cfg_o[2:1] == 2'b00));
  p_pulses_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_o, trip_set_o, trip_clr_o}));
  p_trip_needs_hv_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_set_o || trip_clr_o) |-> $past(hv_i));
  p_cfg_moves_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(stop_i, 2));
  p_read_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> $past(rd_req_i));
  generate
    if (BUSY_CYCLES > 1) begin : g_hold
      p_busy_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || trip_set_o || trip_clr_o) |=> busy_o);
    end
  endgenerate
endmodule

bind ctlreg_cmd_unit ctlreg_cmd_unit_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .byte_vld_i(byte_vld_i),
  .rd_req_i(rd_req_i), .hv_i(hv_i), .ack_vld_o(ack_vld_o), .ack_o(ack_o),
  .rd_vld_o(rd_vld_o), .cfg_o(cfg_o), .commit_o(commit_o),
  .trip_set_o(trip_set_o), .trip_clr_o(trip_clr_o), .busy_o(busy_o)
);

// File: tb/sim_ctlreg_cmd_unit.sv
module sim_ctlreg_cmd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 24;

  logic clk, rst_n, start_i, stop_i, byte_vld_i, rd_req_i, hv_i;
  logic [7:0] byte_i, rd_data_o, cfg_o;
  logic ack_vld_o, ack_o, rd_vld_o, commit_o, trip_set_o, trip_clr_o, trip_sel_o, busy_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_nv;
  bit m_wel, m_rwel;

  ctlreg_cmd_unit #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_req_i(rd_req_i), .hv_i(hv_i),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o),
    .cfg_o(cfg_o), .commit_o(commit_o), .trip_set_o(trip_set_o),
    .trip_clr_o(trip_clr_o), .trip_sel_o(trip_sel_o), .busy_o(busy_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [7:0] exp_cfg();
    return (m_nv & 8'hF1) | {5'b0, m_rwel, m_wel, 1'b0};
  endfunction

  // returns 1 when the byte is a store
  function automatic bit model_data(input logic [7:0] d);
    if (m_rwel) begin
      m_nv = d & 8'hF1; m_wel = 1'b0; m_rwel = 1'b0;
      return 1'b1;
    end
    if (m_wel && d[1] && d[2]) m_rwel = 1'b1;
    else if (d[1] && !d[2])    m_wel = 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
    @(negedge clk) byte_vld_i = 1'b0;
    check(ack_vld_o === 1'b1 && ack_o === exp_ack, req, "ack",
          {30'b0, ack_vld_o, ack_o}, {30'b0, 1'b1, exp_ack});
  endtask

  task automatic do_stop(input bit ec, input bit es, input bit ecl, input bit esel,
                         input string req);
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    check(commit_o === ec && trip_set_o === es && trip_clr_o === ecl &&
          (!(es || ecl) || trip_sel_o === esel), req, "pulses {commit,set,clr,sel}",
          {28'b0, commit_o, trip_set_o, trip_clr_o, trip_sel_o},
          {28'b0, ec, es, ecl, esel});
  endtask

  task automatic wait_idle();
    repeat (BUSY + 2) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d, input string req);
    bit st;
    do_start();
    send(8'hB2, 1'b1, "R3");
    send(8'hFF, 1'b1, "R3");
    send(d, 1'b1, req);
    st = model_data(d);
    do_stop(st, 1'b0, 1'b0, 1'b0, st ? "R5" : req);
    @(negedge clk);
    check(cfg_o === exp_cfg(), req, "cfg after write", {24'b0, cfg_o}, {24'b0, exp_cfg()});
    if (st) wait_idle();
  endtask

  task automatic trip_cmd(input logic [7:0] a, input bit is_set, input bit sel,
                          input string req);
    do_start();
    send(8'hA0, 1'b1, req);
    send(a, 1'b1, req);
    send(8'h00, 1'b1, req);
    do_stop(1'b0, is_set, !is_set, sel, req);
    @(negedge clk);
    check(cfg_o === exp_cfg(), req, "cfg untouched by threshold op",
          {24'b0, cfg_o}, {24'b0, exp_cfg()});
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int busy_len;
    int seed;
    seed = 11;
    void'($urandom(seed));
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; byte_vld_i = 1'b0;
    byte_i = '0; rd_req_i = 1'b0; hv_i = 1'b0;
    m_nv = 8'h00; m_wel = 1'b0; m_rwel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_o === 8'h00 && busy_o === 1'b0 && ack_vld_o === 1'b0 && rd_vld_o === 1'b0 &&
          commit_o === 1'b0 && trip_set_o === 1'b0 && trip_clr_o === 1'b0, "R1",
          "reset state", {24'b0, cfg_o}, 32'h0);

    // R6 write without enables
    reg_write(8'hF1, "R6");
    // R4 unlock, R5 store
    reg_write(8'h02, "R4");
    reg_write(8'h06, "R4");
    // store with busy length measurement
    do_start();
    send(8'hB2, 1'b1, "R3"); send(8'hFF, 1'b1, "R3"); send(8'hA5, 1'b1, "R5");
    void'(model_data(8'hA5));
    do_stop(1'b1, 1'b0, 1'b0, 1'b0, "R5");
    busy_len = 0;
    while (busy_o === 1'b1 && busy_len < 4 * BUSY) begin
      busy_len++;
      if (busy_len == 2)
        check(cfg_o === exp_cfg(), "R5", "stored value", {24'b0, cfg_o}, {24'b0, exp_cfg()});
      @(negedge clk);
    end
    check(busy_len == BUSY, "R13", "busy length", busy_len, BUSY);

    // R9 register read via pointer, then restart
    do_start();
    send(8'hB2, 1'b1, "R9"); send(8'hFF, 1'b1, "R9");
    do_start();
    send(8'hB3, 1'b1, "R9");
    @(negedge clk) rd_req_i = 1'b1;
    @(negedge clk) rd_req_i = 1'b0;
    check(rd_vld_o === 1'b1 && rd_data_o === exp_cfg(), "R9", "read byte",
          {23'b0, rd_vld_o, rd_data_o}, {23'b0, 1'b1, exp_cfg()});
    @(negedge clk) rd_req_i = 1'b1;
    @(negedge clk) rd_req_i = 1'b0;
    check(rd_vld_o === 1'b0, "R9", "second read byte", {31'b0, rd_vld_o}, 32'h0);

    // R3 address decode
    do_start(); send(8'hB2, 1'b1, "R3"); send(8'h7E, 1'b0, "R3");
    do_start(); send(8'hC2, 1'b0, "R3");
    do_start(); send(8'hB0, 1'b0, "R3");
    do_stop(1'b0, 1'b0, 1'b0, 1'b0, "R3");

    // R7 extra data bytes refused
    reg_write(8'h02, "R4");
    reg_write(8'h06, "R4");
    do_start();
    send(8'hB2, 1'b1, "R7"); send(8'hFF, 1'b1, "R7");
    send(8'h50, 1'b1, "R7"); send(8'h3C, 1'b0, "R7");
    void'(model_data(8'h50));
    do_stop(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    @(negedge clk);
    check(cfg_o === exp_cfg(), "R7", "only first byte stored", {24'b0, cfg_o}, {24'b0, exp_cfg()});
    // R13 traffic refused while busy
    do_start(); send(8'hB2, 1'b0, "R13");
    do_stop(1'b0, 1'b0, 1'b0, 1'b0, "R13");
    wait_idle();

    // R8 restart discards pending write
    do_start();
    send(8'hB2, 1'b1, "R8"); send(8'hFF, 1'b1, "R8"); send(8'h02, 1'b1, "R8");
    do_start();
    do_stop(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    @(negedge clk);
    check(cfg_o === exp_cfg(), "R8", "restart discards", {24'b0, cfg_o}, {24'b0, exp_cfg()});

    // R10 / R11 threshold commands
    hv_i = 1'b1;
    trip_cmd(8'h01, 1'b1, 1'b0, "R10");
    trip_cmd(8'h09, 1'b1, 1'b1, "R10");
    trip_cmd(8'h03, 1'b0, 1'b0, "R11");
    trip_cmd(8'h0B, 1'b0, 1'b1, "R11");
    do_start(); send(8'hA0, 1'b1, "R10"); send(8'h01, 1'b1, "R10"); send(8'h5A, 1'b0, "R10");
    do_stop(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    // R12 flag dropped before STOP
    do_start(); send(8'hA0, 1'b1, "R12"); send(8'h03, 1'b1, "R12"); send(8'h00, 1'b1, "R12");
    hv_i = 1'b0;
    do_stop(1'b0, 1'b0, 1'b0, 1'b0, "R12");
    do_start(); send(8'hA0, 1'b0, "R12");
    do_stop(1'b0, 1'b0, 1'b0, 1'b0, "R12");

    // random register traffic
    for (int i = 0; i < 40; i++) begin
      int pick;
      logic [7:0] d;
      pick = int'($urandom_range(0, 3));
      d = (pick == 0) ? 8'h02 : (pick == 1) ? 8'h06 : 8'($urandom);
      reg_write(d, m_rwel ? "R5" : "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule